// File: doc/BRIEF.md
# Power Mode Control Register

This block is one register of a system-basis controller's register file, reached through a serial register port. The port logic in front of it presents an address, a write strobe with a 3-bit command, and a read strobe. A command written to this register sets the operating mode of the chip: normal, standby, stop or sleep. Each of those modes except sleep also has a debug variant in which the watchdog is held off. A read of the register returns four sticky status flags: supply low, regulator temperature warning, general failure and watchdog reset. The read also clears them.

Hardware event pulses from the analog and timer sections set the flags. Two inputs come from a companion control register. One lets the watchdog run during stop. The other must be 1 before sleep is allowed. Sleep is also refused while the supply-low flag is set, so software has to read and clear that flag first. A refused sleep command leaves the mode as it was and gives a one-cycle error pulse. The block drives the current mode, a debug indication and a watchdog-running indication to the rest of the chip.

Top module: `pwr_mode_reg`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns after that edge to `mode` = 0 (normal), `debug` = 0, all four flags cleared and `sleep_err` = 0.
- R2: A write acts only in the first cycle of a write strobe (`wr_en` high with `addr` = 0). Its effect shows after that edge. Commands 3'b001, 3'b010 and 3'b011 select `mode` 0 (normal), 1 (standby) and 2 (stop) with `debug` = 0. Commands 3'b101, 3'b110 and 3'b111 select the same three modes with `debug` = 1.
- R3: Command 3'b000 inverts `debug` and leaves `mode` unchanged. It acts once per strobe, however many cycles the strobe lasts.
- R4: Command 3'b100 moves to `mode` 3 (sleep) with `debug` = 0, but only when the stored supply-low flag is 0 and `no_stop` is 1. Otherwise the mode and debug state stay as they were and `sleep_err` is high for exactly the next cycle.
- R5: `wd_run` is 0 when `debug` is 1 or `mode` is sleep. In stop it equals `wd_stop_en`. In normal and standby it is 1.
- R6: A high level on an event input sets its flag at the next edge. During a read (`rd_en` high with `addr` = 0), `rdata` shows the flags: bit 3 supply low, bit 2 temperature warning, bit 1 general failure, bit 0 watchdog reset. `rdata` is 0 when no read is in progress.
- R7: A read shows the flag values held before the read and clears them at the edge that ends the read cycle. An event present in that same cycle leaves its flag set.
- R8: No write can set a flag. In particular the supply-low flag stays 0 through any write while `evt_supply_low` is low. Writes and reads to any address other than 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on or system) |
| addr | input | 3 | Register address from the serial port logic |
| wr_en | input | 1 | Write strobe |
| wdata | input | 3 | Mode command |
| rd_en | input | 1 | Read strobe |
| rdata | output | 4 | Status flags during a read, else 0 |
| evt_supply_low | input | 1 | Supply fell below the low threshold |
| evt_temp_warn | input | 1 | Regulator over-temperature warning |
| evt_fail | input | 1 | Bus fault, over-temperature or secondary supply low |
| evt_wd_reset | input | 1 | Watchdog reset occurred |
| wd_stop_en | input | 1 | Watchdog runs in stop mode |
| no_stop | input | 1 | Companion permission bit required for sleep |
| mode | output | 2 | 0 normal, 1 standby, 2 stop, 3 sleep |
| debug | output | 1 | Debug variant active |
| wd_run | output | 1 | Watchdog is running |
| sleep_err | output | 1 | One-cycle pulse on a refused sleep command |

## Verification
A wrong mode or debug bit shows on `mode`, `debug` and `wd_run` one cycle after the write edge. It stays visible until the next command, so each write is checked at that cycle. A stale or cleared flag stays hidden until the next read, because it appears only on `rdata` during a read or indirectly through a refused or accepted sleep. The bench therefore reads often and sends sleep commands while the supply-low flag is in both states. A lost edge detect on the write strobe appears as repeated debug toggling while a long strobe is held on command 000.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int CMD_W  = 3;
    localparam int FLAG_W = 4;

    typedef enum logic [1:0] {
        PM_NORMAL  = 2'd0,
        PM_STANDBY = 2'd1,
        PM_STOP    = 2'd2,
        PM_SLEEP   = 2'd3
    } pm_mode_e;

    typedef struct packed {
        logic supply_low;
        logic temp_warn;
        logic gen_fail;
        logic wd_reset;
    } pm_flags_t;

    typedef struct packed {
        pm_mode_e mode;
        logic     debug;
    } pm_state_t;

    typedef struct packed {
        logic      toggle;
        logic      sleep;
        pm_state_t target;
    } pm_cmd_t;

    function automatic pm_cmd_t decode_cmd(input logic [CMD_W-1:0] code);
        pm_cmd_t c;
        c.toggle       = (code == 3'b000);
        c.sleep        = (code == 3'b100);
        c.target.debug = code[2];
        unique case (code[1:0])
            2'b01:   c.target.mode = PM_NORMAL;
            2'b10:   c.target.mode = PM_STANDBY;
            2'b11:   c.target.mode = PM_STOP;
            default: c.target.mode = PM_SLEEP;
        endcase
        if (c.sleep) c.target.debug = 1'b0;
        return c;
    endfunction

    function automatic logic wd_allowed(input pm_state_t s, input logic stop_en);
        logic r;
        if (s.debug)                r = 1'b0;
        else if (s.mode == PM_SLEEP) r = 1'b0;
        else if (s.mode == PM_STOP)  r = stop_en;
        else                         r = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/pmc_access.sv
module pmc_access #(
    parameter int ADDR_W   = 3,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic              wr_hit,
    output logic              wr_pulse,
    output logic              rd_hit
);
    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

    logic sel;
    logic wr_hit_q;

    assign sel      = (addr == MATCH);
    assign wr_hit   = wr_en & sel;
    assign rd_hit   = rd_en & sel;
    assign wr_pulse = wr_hit & ~wr_hit_q;

    always_ff @(posedge clk) begin
        if (rst) wr_hit_q <= 1'b0;
        else     wr_hit_q <= wr_hit;
    end
endmodule

// File: rtl/pmc_status.sv
module pmc_status
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_hit,
    input  pm_flags_t events,
    output pm_flags_t flags
);
    pm_flags_t keep;

    always_comb begin
        keep = rd_hit ? '0 : flags;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= keep | events;
    end
endmodule

// File: rtl/pmc_mode.sv
module pmc_mode
    import pmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_pulse,
    input  logic [CMD_W-1:0] cmd,
    input  logic             supply_flag,
    input  logic             no_stop,
    output pm_state_t        state,
    output logic             sleep_err
);
    pm_cmd_t   dec;
    pm_state_t nxt;
    logic      err_nxt;
    logic      sleep_ok;

    always_comb begin
        dec      = decode_cmd(cmd);
        sleep_ok = ~supply_flag & no_stop;
        nxt      = state;
        err_nxt  = 1'b0;
        if (wr_pulse) begin
            if (dec.toggle) begin
                nxt.debug = ~state.debug;
            end else if (dec.sleep) begin
                if (sleep_ok) nxt = dec.target;
                else          err_nxt = 1'b1;
            end else begin
                nxt = dec.target;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= '{mode: PM_NORMAL, debug: 1'b0};
            sleep_err <= 1'b0;
        end else begin
            state     <= nxt;
            sleep_err <= err_nxt;
        end
    end
endmodule

// File: rtl/pwr_mode_reg.sv
module pwr_mode_reg
    import pmc_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int REG_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wdata,
    input  logic              rd_en,
    output logic [FLAG_W-1:0] rdata,
    input  logic              evt_supply_low,
    input  logic              evt_temp_warn,
    input  logic              evt_fail,
    input  logic              evt_wd_reset,
    input  logic              wd_stop_en,
    input  logic              no_stop,
    output logic [1:0]        mode,
    output logic              debug,
    output logic              wd_run,
    output logic              sleep_err
);
    logic      wr_hit;
    logic      wr_pulse;
    logic      rd_hit;
    pm_flags_t events;
    pm_flags_t flags;
    pm_state_t state;
    logic [FLAG_W-1:0] flag_vec;

    assign events = '{supply_low: evt_supply_low, temp_warn: evt_temp_warn,
                      gen_fail: evt_fail, wd_reset: evt_wd_reset};

    pmc_access #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_access (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wr_hit(wr_hit), .wr_pulse(wr_pulse), .rd_hit(rd_hit)
    );

    pmc_status u_status (
        .clk(clk), .rst(rst), .rd_hit(rd_hit), .events(events), .flags(flags)
    );

    pmc_mode u_mode (
        .clk(clk), .rst(rst), .wr_pulse(wr_pulse), .cmd(wdata),
        .supply_flag(flags.supply_low), .no_stop(no_stop),
        .state(state), .sleep_err(sleep_err)
    );

    assign flag_vec = flags;
    assign rdata    = rd_hit ? flag_vec : '0;
    assign mode     = state.mode;
    assign debug    = state.debug;
    assign wd_run   = wd_allowed(state, wd_stop_en);
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_hit,
    input logic       rd_hit,
    input logic       wr_pulse,
    input logic [2:0] wdata,
    input logic [3:0] flag_vec,
    input logic       evt_supply_low,
    input logic       no_stop,
    input logic [1:0] mode,
    input logic       debug,
    input logic       wd_run,
    input logic       sleep_err
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mode == 2'd0 && !debug && flag_vec == 4'd0 && !sleep_err));

    p_toggle_once_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !wr_pulse) |=> (debug == $past(debug) && mode == $past(mode)));

    p_reject_holds_r4: assert property (@(posedge clk) disable iff (rst)
        sleep_err |-> (mode == $past(mode) && debug == $past(debug)));

    p_err_single_r4: assert property (@(posedge clk) disable iff (rst)
        sleep_err |=> !sleep_err);

    p_sleep_entry_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_pulse && wdata == 3'b100 && (flag_vec[3] || !no_stop)) |=> sleep_err);

    p_wd_off_sleep_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 || debug) |-> !wd_run);

    p_event_latch_r6: assert property (@(posedge clk) disable iff (rst)
        evt_supply_low |=> flag_vec[3]);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (!rd_hit && flag_vec[3]) |=> flag_vec[3]);

    p_no_write_set_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !evt_supply_low && !flag_vec[3]) |=> !flag_vec[3]);
endmodule

bind pwr_mode_reg pmc_checker u_checker (
    .clk(clk), .rst(rst), .wr_hit(wr_hit), .rd_hit(rd_hit), .wr_pulse(wr_pulse),
    .wdata(wdata), .flag_vec(flag_vec), .evt_supply_low(evt_supply_low),
    .no_stop(no_stop), .mode(mode), .debug(debug), .wd_run(wd_run),
    .sleep_err(sleep_err)
);

// File: tb/test_pwr_mode_reg.sv
module test_pwr_mode_reg;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] addr;
    logic       wr_en, rd_en;
    logic [2:0] wdata;
    logic [3:0] rdata;
    logic       evt_supply_low, evt_temp_warn, evt_fail, evt_wd_reset;
    logic       wd_stop_en, no_stop;
    logic [1:0] mode;
    logic       debug, wd_run, sleep_err;

    int checks = 0;
    int errors = 0;

    int         m_mode;
    logic       m_dbg, m_wrq, m_err;
    logic [3:0] m_flags;

    always #2.5 clk = ~clk;

    pwr_mode_reg i_pwr_mode_reg (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .evt_supply_low(evt_supply_low),
        .evt_temp_warn(evt_temp_warn), .evt_fail(evt_fail),
        .evt_wd_reset(evt_wd_reset), .wd_stop_en(wd_stop_en), .no_stop(no_stop),
        .mode(mode), .debug(debug), .wd_run(wd_run), .sleep_err(sleep_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_wd(input int md, input logic dbg, input logic wse);
        if (dbg || md == 3) return 1'b0;
        if (md == 2) return wse;
        return 1'b1;
    endfunction

    // One cycle: drive at negedge, check rdata, model the edge, check state
    task automatic step(input logic wr, input logic rd, input logic [2:0] a,
                        input logic [2:0] d, input logic [3:0] ev,
                        input logic wse, input logic ns);
        logic hit_w, hit_r;
        addr = a; wr_en = wr; rd_en = rd; wdata = d;
        {evt_supply_low, evt_temp_warn, evt_fail, evt_wd_reset} = ev;
        wd_stop_en = wse; no_stop = ns;
        #1;
        hit_w = wr && (a == 3'd0);
        hit_r = rd && (a == 3'd0);
        check("R6 rdata", rdata, hit_r ? m_flags : 4'd0);
        m_err = 1'b0;
        if (hit_w && !m_wrq) begin
            case (d)
                3'd0: m_dbg = ~m_dbg;
                3'd1, 3'd2, 3'd3: begin m_mode = d - 1; m_dbg = 1'b0; end
                3'd5, 3'd6, 3'd7: begin m_mode = d - 5; m_dbg = 1'b1; end
                default: begin
                    if (!m_flags[3] && ns) begin m_mode = 3; m_dbg = 1'b0; end
                    else m_err = 1'b1;
                end
            endcase
        end
        m_flags = (hit_r ? 4'd0 : m_flags) | ev;
        m_wrq = hit_w;
        @(negedge clk);
        check("R2 mode", mode, m_mode);
        check("R3 debug", debug, m_dbg);
        check("R4 sleep_err", sleep_err, m_err);
        check("R5 wd_run", wd_run, exp_wd(m_mode, m_dbg, wse));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 3'd0, 3'd0, 4'd0, 1'b0, 1'b1);
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; addr = 0; wr_en = 0; rd_en = 0; wdata = 0;
        {evt_supply_low, evt_temp_warn, evt_fail, evt_wd_reset} = 4'd0;
        wd_stop_en = 0; no_stop = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mode", mode, 0);
        check("R1 debug", debug, 0);
        check("R1 sleep_err", sleep_err, 0);
        rst = 1'b0;
        m_mode = 0; m_dbg = 0; m_wrq = 0; m_flags = 0; m_err = 0;
        step(0, 1, 3'd0, 3'd0, 4'd0, 1'b0, 1'b0);   // R1 flags read as 0

        // R2: plain and debug variants
        step(1, 0, 3'd0, 3'd2, 4'd0, 1'b1, 1'b1); idle(1);
        step(1, 0, 3'd0, 3'd7, 4'd0, 1'b1, 1'b1); idle(1);
        step(1, 0, 3'd0, 3'd3, 4'd0, 1'b0, 1'b1); idle(1);   // R5 stop, wd off
        step(1, 0, 3'd0, 3'd3, 4'd0, 1'b1, 1'b1); idle(1);   // R5 stop, wd on

        // R3: long strobe on toggle acts once
        for (int i = 0; i < 4; i++) step(1, 0, 3'd0, 3'd0, 4'd0, 1'b1, 1'b1);
        idle(1);

        // R4: sleep refused by supply flag, then by no_stop, then accepted
        step(0, 0, 3'd0, 3'd0, 4'b1000, 1'b0, 1'b1);
        step(1, 0, 3'd0, 3'd4, 4'd0, 1'b0, 1'b1); idle(1);
        // R7: read with a coincident temperature event
        step(0, 1, 3'd0, 3'd0, 4'b0100, 1'b0, 1'b1);
        step(0, 1, 3'd0, 3'd0, 4'd0, 1'b0, 1'b1);
        step(1, 0, 3'd0, 3'd4, 4'd0, 1'b0, 1'b0); idle(1);
        step(1, 0, 3'd0, 3'd4, 4'd0, 1'b1, 1'b1); idle(1);

        // R8: other address ignored, write does not set flags
        step(1, 0, 3'd5, 3'd1, 4'd0, 1'b0, 1'b1);
        step(1, 1, 3'd3, 3'd7, 4'b0011, 1'b0, 1'b1);
        step(0, 1, 3'd0, 3'd0, 4'd0, 1'b0, 1'b1);
        step(1, 0, 3'd0, 3'd1, 4'd0, 1'b0, 1'b1); idle(1);
        step(0, 1, 3'd0, 3'd0, 4'd0, 1'b0, 1'b1);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ev;
            ev = 4'd0;
            for (int b = 0; b < 4; b++) ev[b] = ($urandom_range(0, 19) == 0);
            step($urandom_range(0, 9) < 3, $urandom_range(0, 9) < 2,
                 ($urandom_range(0, 9) < 8) ? 3'd0 : 3'($urandom_range(1, 7)),
                 3'($urandom_range(0, 7)), ev,
                 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule